// File: doc/BRIEF.md
# Dual-Channel Phase-Frequency Detector with Lock Qualification

This block compares, for each of two synthesizer channels, a reference strobe against a divided feedback strobe. Both are one-clock pulses synchronous to the oscillator clock. The block turns the order and the spacing of those strobes into a three-state charge-pump command: drive high, drive low, or float. It uses a classic two-flop detector, so a frequency error as well as a phase error keeps the pump pushing in one direction. The sense of the command can be set per channel to suit the polarity of the loop filter and the oscillator.

Each channel measures how many oscillator clocks the pump is driven for each comparison. A lock qualifier uses that width. One wide comparison drops the lock flag at once. The flag comes back only after a run of consecutive narrow comparisons. Each channel has a power-save input. While it is set, the channel floats its pump and reports locked. When it is released, the channel restarts cleanly and waits for a reference strobe, so the restart does not kick the oscillator. A combined flag reports that every channel is locked.

Top module: `dual_pfd_lock`

## Requirements
- R1: With the polarity bit at 1, a reference strobe that arrives while no comparison is open drives the channel pump to code 2'b11 (high), starting the clock after the strobe. Pump codes are two bits per channel at pump_o[2c+1:2c]: bit 1 is drive enable and bit 0 is level, so 2'b00 means float.
- R2: With the polarity bit at 0, the high and low codes are swapped for both lead directions, and the equal case still floats.
- R3: Reference and feedback strobes in the same clock close the comparison with width 0, and the pump stays at 2'b00.
- R4: The pump is driven for exactly as many clocks as separate the leading strobe from the lagging strobe. A one-clock error gives a full one-clock pulse. The pump returns to 2'b00 in the clock after the lagging strobe.
- R5: With the polarity bit at 1, a feedback strobe that leads drives code 2'b10 (low) until the reference strobe arrives.
- R6: The channel lock flag rises at the close of the LOCK_CNT-th (default 3) consecutive comparison whose width is at most LOCK_W (default 2) clocks.
- R7: A comparison of width UNLOCK_W (default 4) or more clears the lock flag at its close. A width strictly between LOCK_W and UNLOCK_W leaves the flag unchanged but restarts the narrow-run count.
- R8: While a channel's power-save input is 1, its pump reads 2'b00 in the same cycle, its lock flag reads 1, and its strobes have no effect.
- R9: all_lock is 1 exactly when every channel lock flag is 1.
- R10: After reset, and after power-save is released, the channel lock flag reads 0. Feedback strobes are then ignored, with the pump held at 2'b00, until the first reference strobe. That strobe starts a normal comparison.
- R11: Channels are independent. Activity on one channel never changes the pump or lock flag of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_stb | input | NCH | Per-channel one-clock reference strobe |
| fb_stb | input | NCH | Per-channel one-clock divided feedback strobe |
| pol | input | NCH | Per-channel pump polarity (1: reference lead drives high) |
| sleep | input | NCH | Per-channel power-save request |
| pump_o | output | 2*NCH | Per-channel pump command {drive, level} |
| ch_lock | output | NCH | Per-channel lock flag |
| all_lock | output | 1 | AND of all channel lock flags |

## Verification
The closing of a comparison and the start of the next one can fall in the same clock. So can a power-save request and an open error window. The bench provokes the first case with coincident strobes and with back-to-back comparisons whose lagging strobe is followed at once by a new lead. It provokes the second by raising power-save while the pump is driving. Each is judged by the pump code sampled mid-cycle and by the lock flag, against a bench model of the narrow-run count and of the re-arm rule. A sweep of lead and lag distances from −6 to +6 clocks under both polarities checks every width class: narrow, middle and wide.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

   typedef enum logic [1:0] {
      PUMP_Z  = 2'b00,
      PUMP_LO = 2'b10,
      PUMP_HI = 2'b11
   } pump_e;

   // Map detector state and polarity onto a pump command.
   function automatic pump_e pump_code(input logic up, input logic dn, input logic pol);
      pump_e c;
      if (up)
         c = pol ? PUMP_HI : PUMP_LO;
      else if (dn)
         c = pol ? PUMP_LO : PUMP_HI;
      else
         c = PUMP_Z;
      return c;
   endfunction

endpackage

// File: rtl/pfd_phase_core.sv
module pfd_phase_core
   import pfd_pkg::*;
#(
   parameter int UNLOCK_W = 4,
   parameter int CW       = $clog2(UNLOCK_W + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sleep,
   input  logic          pol,
   input  logic          fr,
   input  logic          fp,
   output pump_e         pump,
   output logic          close_v,
   output logic [CW-1:0] width
);

   localparam logic [CW-1:0] CNT_MAX = CW'(UNLOCK_W - 1);

   logic          up_q, dn_q, arm_q;
   logic [CW-1:0] cnt_q;
   logic          fp_ok, nxt_up, nxt_dn, both, act, nxt_act;

   always_comb begin
      fp_ok   = fp & arm_q;
      nxt_up  = up_q | fr;
      nxt_dn  = dn_q | fp_ok;
      both    = nxt_up & nxt_dn;
      act     = up_q | dn_q;
      nxt_act = (nxt_up | nxt_dn) & ~both;
      close_v = ~sleep & ((act & ~nxt_act) | (~act & fr & fp_ok));
      width   = act ? (cnt_q + CW'(1)) : '0;
      pump    = sleep ? PUMP_Z : pump_code(up_q, dn_q, pol);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         up_q  <= 1'b0;
         dn_q  <= 1'b0;
         arm_q <= 1'b0;
         cnt_q <= '0;
      end else if (sleep) begin
         up_q  <= 1'b0;
         dn_q  <= 1'b0;
         arm_q <= 1'b0;
         cnt_q <= '0;
      end else begin
         up_q  <= nxt_up & ~both;
         dn_q  <= nxt_dn & ~both;
         arm_q <= arm_q | fr;
         if (act & nxt_act)
            cnt_q <= (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CW'(1);
         else
            cnt_q <= '0;
      end
   end

   // R1
   ref_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && !up_q && !dn_q && fr && !fp) |=> up_q);

   // R4
   hold_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && up_q && !(fp && arm_q)) |=> up_q);

   // R10
   restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sleep) |-> (!up_q && !dn_q && !arm_q));

   // R10
   ignore_fb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!arm_q && !fr) |=> !dn_q);

   // R3
   excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({up_q, dn_q}));

endmodule

// File: rtl/pfd_lock_qual.sv
module pfd_lock_qual #(
   parameter int LOCK_W   = 2,
   parameter int UNLOCK_W = 4,
   parameter int LOCK_CNT = 3,
   parameter int CW       = $clog2(UNLOCK_W + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sleep,
   input  logic          close_v,
   input  logic [CW-1:0] width,
   output logic          lock_o
);

   localparam int            RW      = $clog2(LOCK_CNT + 1);
   localparam logic [RW-1:0] RUN_MAX = RW'(LOCK_CNT);

   logic          lock_q;
   logic [RW-1:0] run_q, nrun;
   logic          wide, narrow;

   always_comb begin
      wide   = (width >= CW'(UNLOCK_W));
      narrow = (width <= CW'(LOCK_W));
      nrun   = (run_q == RUN_MAX) ? run_q : run_q + RW'(1);
      lock_o = sleep | lock_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q <= 1'b0;
         run_q  <= '0;
      end else if (sleep) begin
         lock_q <= 1'b0;
         run_q  <= '0;
      end else if (close_v) begin
         if (wide) begin
            lock_q <= 1'b0;
            run_q  <= '0;
         end else if (narrow) begin
            run_q <= nrun;
            if (nrun >= RUN_MAX)
               lock_q <= 1'b1;
         end else begin
            run_q <= '0;
         end
      end
   end

   // R6
   rise_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_q) |-> ($past(close_v) && ($past(width) <= CW'(LOCK_W))));

   // R7
   wide_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (close_v && !sleep && (width >= CW'(UNLOCK_W))) |=> !lock_q);

   // R8
   sleep_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |=> (!lock_q && (run_q == '0)));

endmodule

// File: rtl/dual_pfd_lock.sv
module dual_pfd_lock
   import pfd_pkg::*;
#(
   parameter int NCH      = 2,
   parameter int LOCK_W   = 2,
   parameter int UNLOCK_W = 4,
   parameter int LOCK_CNT = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NCH-1:0]   ref_stb,
   input  logic [NCH-1:0]   fb_stb,
   input  logic [NCH-1:0]   pol,
   input  logic [NCH-1:0]   sleep,
   output logic [2*NCH-1:0] pump_o,
   output logic [NCH-1:0]   ch_lock,
   output logic             all_lock
);

   localparam int CW = $clog2(UNLOCK_W + 1);

   if (NCH < 1) begin : g_bad_nch
      $error("dual_pfd_lock: NCH must be at least 1");
   end
   if (UNLOCK_W < 2) begin : g_bad_unlock
      $error("dual_pfd_lock: UNLOCK_W must be at least 2");
   end
   if (LOCK_W >= UNLOCK_W) begin : g_bad_window
      $error("dual_pfd_lock: LOCK_W must be below UNLOCK_W");
   end
   if (LOCK_CNT < 1) begin : g_bad_cnt
      $error("dual_pfd_lock: LOCK_CNT must be at least 1");
   end

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      pump_e         pump_w;
      logic          close_w;
      logic [CW-1:0] width_w;

      pfd_phase_core #(
         .UNLOCK_W (UNLOCK_W),
         .CW       (CW)
      ) u_core (
         .clk     (clk),
         .rst_n   (rst_n),
         .sleep   (sleep[c]),
         .pol     (pol[c]),
         .fr      (ref_stb[c]),
         .fp      (fb_stb[c]),
         .pump    (pump_w),
         .close_v (close_w),
         .width   (width_w)
      );

      pfd_lock_qual #(
         .LOCK_W   (LOCK_W),
         .UNLOCK_W (UNLOCK_W),
         .LOCK_CNT (LOCK_CNT),
         .CW       (CW)
      ) u_qual (
         .clk     (clk),
         .rst_n   (rst_n),
         .sleep   (sleep[c]),
         .close_v (close_w),
         .width   (width_w),
         .lock_o  (ch_lock[c])
      );

      assign pump_o[2*c +: 2] = pump_w;
   end

   assign all_lock = &ch_lock;

   // R9
   all_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_lock != {NCH{1'b1}}) |-> !all_lock);

endmodule

// File: tb/sim_dual_pfd_lock.sv
`timescale 1ns/1ps
module sim_dual_pfd_lock;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] ref_stb = '0, fb_stb = '0, pol = 2'b01, sleep = 2'b10;
   logic [3:0] pump_o;
   logic [1:0] ch_lock;
   logic       all_lock;

   int n_chk = 0, n_err = 0;
   bit done = 0;
   bit m_lock [2];
   int m_run  [2];

   always #10 clk = ~clk;

   dual_pfd_lock u0 (
      .clk(clk), .rst_n(rst_n), .ref_stb(ref_stb), .fb_stb(fb_stb),
      .pol(pol), .sleep(sleep), .pump_o(pump_o), .ch_lock(ch_lock),
      .all_lock(all_lock)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic strobe(input int ch, input bit r, input bit f);
      ref_stb[ch] = r;
      fb_stb[ch]  = f;
      tick();
      ref_stb[ch] = 1'b0;
      fb_stb[ch]  = 1'b0;
   endtask

   function automatic logic [7:0] pcode(input int ch);
      return {6'd0, pump_o[2*ch +: 2]};
   endfunction

   function automatic logic [7:0] exp_all();
      return {7'd0, (sleep[0] | m_lock[0]) & (sleep[1] | m_lock[1])};
   endfunction

   // One comparison: d>0 reference leads by d clocks, d<0 feedback leads, 0 coincident.
   task automatic run_cmp(input int ch, input int d);
      int    mag;
      bit    lvl;
      string tag;
      mag = (d < 0) ? -d : d;
      lvl = (d > 0) ? pol[ch] : ~pol[ch];
      tag = (pol[ch] == 1'b0) ? "R2" : ((d > 0) ? "R1" : "R5");
      if (d == 0) begin
         strobe(ch, 1'b1, 1'b1);
         chk("R3 coincident float", pcode(ch), 8'd0);
      end else begin
         strobe(ch, d > 0, d < 0);
         chk(tag, pcode(ch), {6'd0, 1'b1, lvl});
         for (int i = 1; i < mag; i++) begin
            tick();
            chk("R4 drive held", pcode(ch), {6'd0, 1'b1, lvl});
         end
         strobe(ch, d < 0, d > 0);
         chk("R4 release", pcode(ch), 8'd0);
      end
      if (mag >= 4) begin
         m_lock[ch] = 1'b0;
         m_run[ch]  = 0;
      end else if (mag <= 2) begin
         m_run[ch] = m_run[ch] + 1;
         if (m_run[ch] >= 3) m_lock[ch] = 1'b1;
      end else begin
         m_run[ch] = 0;
      end
      chk((mag >= 4) ? "R7 wide" : "R6 qualify", {7'd0, ch_lock[ch]}, {7'd0, m_lock[ch]});
      chk("R9 combined", {7'd0, all_lock}, exp_all());
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog: got 0 expected 1");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      m_lock = '{0, 0};
      m_run  = '{0, 0};
      repeat (3) @(negedge clk);
      chk("R8 reset pump", {4'd0, pump_o}, 8'd0);
      chk("R8 reset locks", {6'd0, ch_lock}, 8'd2);
      chk("R9 reset all", {7'd0, all_lock}, 8'd0);
      rst_n = 1'b1;
      tick();

      // R10: unarmed after reset, feedback ignored
      strobe(0, 1'b0, 1'b1);
      chk("R10 fb ignored", pcode(0), 8'd0);
      tick();
      chk("R10 fb ignored later", pcode(0), 8'd0);

      run_cmp(0, 1);
      run_cmp(0, 0);
      run_cmp(0, -2);
      run_cmp(0, 3);   // middle width: lock held, run restarts
      run_cmp(0, 1);
      run_cmp(0, 2);
      run_cmp(0, 5);   // wide: lock drops
      for (int p = 1; p >= 0; p--) begin
         pol[0] = p[0];
         for (int d = -6; d <= 6; d++) run_cmp(0, d);
      end
      pol[0] = 1'b1;

      // R8: asleep channel ignores strobes
      strobe(1, 1'b1, 1'b0);
      chk("R8 sleep pump", pcode(1), 8'd0);
      chk("R8 sleep lock", {7'd0, ch_lock[1]}, 8'd1);

      // R8: sleep raised while pump is driving
      strobe(0, 1'b1, 1'b0);
      chk("R1 before sleep", pcode(0), 8'd3);
      sleep[0] = 1'b1;
      #1;
      chk("R8 sleep mid-error pump", pcode(0), 8'd0);
      chk("R8 sleep mid-error lock", {7'd0, ch_lock[0]}, 8'd1);
      tick();
      sleep[0] = 1'b0;
      m_lock[0] = 1'b0;
      m_run[0]  = 0;
      tick();
      chk("R10 lock after wake", {7'd0, ch_lock[0]}, 8'd0);
      strobe(0, 1'b0, 1'b1);
      chk("R10 fb ignored after wake", pcode(0), 8'd0);
      run_cmp(0, 2);
      run_cmp(0, 1);
      run_cmp(0, 0);

      // Channel 1 with inverted polarity
      sleep[1] = 1'b0;
      pol[1]   = 1'b0;
      tick();
      chk("R10 ch1 lock after wake", {7'd0, ch_lock[1]}, 8'd0);
      chk("R9 all after ch1 wake", {7'd0, all_lock}, 8'd0);
      run_cmp(1, 2);
      chk("R11 ch0 pump untouched", pcode(0), 8'd0);
      chk("R11 ch0 lock untouched", {7'd0, ch_lock[0]}, {7'd0, m_lock[0]});
      run_cmp(1, -1);
      run_cmp(1, 0);
      chk("R9 both locked", {7'd0, all_lock}, 8'd1);
      run_cmp(1, 4);
      chk("R11 ch0 lock after ch1 drop", {7'd0, ch_lock[0]}, 8'd1);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule